// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external controller configure and inspect a chip over a four-wire serial link. The controller raises a select line, toggles a serial clock and presents one bit per clock on a data input. Every access starts with a direction bit, then a register address, then eight data bits. On a write, the data lands in a small bank of configuration registers. On a read, the block returns the addressed register or a live status byte on a serial data output. The output has its own enable so that a pad driver can tri-state it.

The serial select, clock and data are brought into the block's own system clock domain through two-stage synchronizers. Serial clock edges are then detected there. The system clock must run at least eight times faster than the serial clock. Serial access at 20 MHz therefore needs a system clock of 160 MHz or more. Outside its own read bit times the output enable stays low. Several devices can then share the clock and data wires, and the data input and output can be joined into one bidirectional line.

Configuration register i (address i, for i below NUM_CFG) resets to 0x30 + i. Status byte j is read at address STAT_BASE + j (0x10 and 0x11 by default) and comes straight from the statusIn input.

Top module: `serial_reg_slave`

## Requirements
- R1: While rstN is low and after it is released, configuration register i holds 0x30 + i and sdOe is low.
- R2: A frame is sixteen serial clocks with selIn high, and every input bit is captured on a rising edge of sclkIn. The first bit is the direction (1 = read, 0 = write). The next seven bits are the address, least significant bit first. The last eight bits are the data, least significant bit first.
- R3: A write to configuration address i (below NUM_CFG) sets register i to the eight data bits. The register changes only after the eighth data bit has been captured.
- R4: On a read, the addressed value is driven on sdOut least significant bit first. Bit 0 appears at the falling sclkIn edge that follows the last address bit, and each later bit appears at the next falling edge.
- R5: sdOe is high only for the eight data bit times of a read. It rises at the falling edge after the last address bit and falls at the falling edge after the last data bit. It stays low for the whole of a write frame and whenever selIn is low.
- R6: Dropping selIn before a frame is complete abandons it. No register is written, sdOe goes low, and the next frame is decoded from its first bit.
- R7: Reading address STAT_BASE + j returns the current value of status byte j of statusIn. Writes to those addresses change no configuration register.
- R8: Reading an address that is neither a configuration nor a status address returns 0x00. Writing one changes no configuration register.
- R9: Consecutive frames, each framed by its own select period, are decoded independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rstN | input | 1 | Active-low synchronous reset |
| selIn | input | 1 | Serial select, high for the duration of a frame |
| sclkIn | input | 1 | Serial clock |
| sdIn | input | 1 | Serial data input |
| sdOut | output | 1 | Serial data output (low whenever sdOe is low) |
| sdOe | output | 1 | Output enable for the serial data pad driver |
| statusIn | input | NUM_STAT*8 | Live status bytes, byte j at address STAT_BASE + j |
| cfgOut | output | NUM_CFG*8 | Configuration registers, register i in byte i |

## Verification
The checker assumes that selIn changes only while sclkIn is low. It also assumes that every serial clock level lasts several system clocks, so the synchronized edges never merge. The stimulus holds each serial clock level for five system clocks and always changes select and data in the low phase. The bench samples sdOut and sdOe shortly before each rising serial edge, as a real master would. Its model is a plain array of register contents plus the live status bytes, updated at the end of every complete write frame.

// File: rtl/serial_reg_pkg.sv
package serial_reg_pkg;

  // Per-cycle commands issued by the frame control to the datapath.
  typedef struct packed {
    logic bitVal;       // synchronized serial data bit
    logic shiftAddr;    // capture an address bit
    logic shiftData;    // capture a data bit
    logic commitWrite;  // final data bit present: write register
    logic loadRead;     // load read value into transmit shifter
    logic shiftRead;    // advance transmit shifter
  } strobe_t;

endpackage

// File: rtl/serial_ctrl.sv
module serial_ctrl
  import serial_reg_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int FRAME = 1 + ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(FRAME + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selIn,
  input  logic             sclkIn,
  input  logic             sdIn,
  output strobe_t          strb,
  output logic             oe,
  output logic             rdFlag,
  output logic [CNT_W-1:0] bitCnt,
  output logic             selSync
);

  logic [2:0] sclkSh;
  logic [1:0] selSh;
  logic [1:0] sdSh;
  logic       rise;
  logic       fall;
  logic       riseAct;
  logic       fallAct;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkSh <= '0;
      selSh  <= '0;
      sdSh   <= '0;
    end else begin
      sclkSh <= {sclkSh[1:0], sclkIn};
      selSh  <= {selSh[0], selIn};
      sdSh   <= {sdSh[0], sdIn};
    end
  end

  assign selSync = selSh[1];
  assign rise    = sclkSh[1] & ~sclkSh[2];
  assign fall    = ~sclkSh[1] & sclkSh[2];
  assign riseAct = rise & selSync;
  assign fallAct = fall & selSync;

  always_comb begin
    strb             = '0;
    strb.bitVal      = sdSh[1];
    strb.shiftAddr   = riseAct && (bitCnt >= CNT_W'(1)) && (bitCnt <= CNT_W'(ADDR_W));
    strb.shiftData   = riseAct && (bitCnt > CNT_W'(ADDR_W)) && (bitCnt < CNT_W'(FRAME));
    strb.commitWrite = riseAct && !rdFlag && (bitCnt == CNT_W'(FRAME - 1));
    strb.loadRead    = fallAct && rdFlag && (bitCnt == CNT_W'(ADDR_W + 1));
    strb.shiftRead   = fallAct && oe && (bitCnt > CNT_W'(ADDR_W + 1))
                       && (bitCnt < CNT_W'(FRAME));
  end

  always_ff @(posedge clk) begin
    if (!rstN || !selSync) begin
      bitCnt <= '0;
      rdFlag <= 1'b0;
      oe     <= 1'b0;
    end else begin
      if (riseAct && bitCnt == '0) rdFlag <= sdSh[1];
      if (riseAct && bitCnt < CNT_W'(FRAME)) bitCnt <= bitCnt + 1'b1;
      if (strb.loadRead) oe <= 1'b1;
      else if (fallAct && bitCnt == CNT_W'(FRAME)) oe <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_dp.sv
module serial_dp
  import serial_reg_pkg::*;
#(
  parameter int ADDR_W         = 7,
  parameter int DATA_W         = 8,
  parameter int NUM_CFG        = 4,
  parameter int NUM_STAT       = 2,
  parameter int STAT_BASE      = 16,
  parameter int CFG_RESET_BASE = 48
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   strb,
  input  logic [NUM_STAT*DATA_W-1:0] statusIn,
  output logic [NUM_CFG*DATA_W-1:0]  cfgOut,
  output logic                      txBit
);

  logic [ADDR_W-1:0] addrSh;
  logic [DATA_W-1:0] dataSh;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] rdVal;
  logic [DATA_W-1:0] txSh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrSh <= '0;
      dataSh <= '0;
    end else begin
      if (strb.shiftAddr) addrSh <= {strb.bitVal, addrSh[ADDR_W-1:1]};
      if (strb.shiftData) dataSh <= {strb.bitVal, dataSh[DATA_W-1:1]};
    end
  end

  assign wrData = {strb.bitVal, dataSh[DATA_W-1:1]};

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rstN)
        cfgOut[i*DATA_W +: DATA_W] <= DATA_W'(CFG_RESET_BASE + i);
      else if (strb.commitWrite && addrSh == ADDR_W'(i))
        cfgOut[i*DATA_W +: DATA_W] <= wrData;
    end
  end

  always_comb begin
    rdVal = '0;
    for (int i = 0; i < NUM_CFG; i++)
      if (addrSh == ADDR_W'(i)) rdVal = cfgOut[i*DATA_W +: DATA_W];
    for (int j = 0; j < NUM_STAT; j++)
      if (addrSh == ADDR_W'(STAT_BASE + j)) rdVal = statusIn[j*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN)               txSh <= '0;
    else if (strb.loadRead)  txSh <= rdVal;
    else if (strb.shiftRead) txSh <= {1'b0, txSh[DATA_W-1:1]};
  end

  assign txBit = txSh[0];

endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
  import serial_reg_pkg::*;
#(
  parameter int ADDR_W         = 7,
  parameter int DATA_W         = 8,
  parameter int NUM_CFG        = 4,
  parameter int NUM_STAT       = 2,
  parameter int STAT_BASE      = 16,
  parameter int CFG_RESET_BASE = 48,
  localparam int CNT_W = $clog2(ADDR_W + DATA_W + 2)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       selIn,
  input  logic                       sclkIn,
  input  logic                       sdIn,
  output logic                       sdOut,
  output logic                       sdOe,
  input  logic [NUM_STAT*DATA_W-1:0] statusIn,
  output logic [NUM_CFG*DATA_W-1:0]  cfgOut
);

  strobe_t          strb;
  logic             oe;
  logic             rdFlag;
  logic [CNT_W-1:0] bitCnt;
  logic             selSync;
  logic             txBit;

  serial_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .selIn(selIn), .sclkIn(sclkIn), .sdIn(sdIn),
    .strb(strb), .oe(oe), .rdFlag(rdFlag), .bitCnt(bitCnt), .selSync(selSync)
  );

  serial_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .NUM_STAT(NUM_STAT),
    .STAT_BASE(STAT_BASE), .CFG_RESET_BASE(CFG_RESET_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .statusIn(statusIn),
    .cfgOut(cfgOut), .txBit(txBit)
  );

  assign sdOe  = oe;
  assign sdOut = oe & txBit;

endmodule

// File: rtl/serial_reg_checker.sv
module serial_reg_checker
  import serial_reg_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 8,
  parameter int NUM_CFG = 4,
  parameter int CNT_W   = 5
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      selIn,
  input logic                      sdOut,
  input logic                      sdOe,
  input logic [NUM_CFG*DATA_W-1:0] cfgOut,
  input strobe_t                   strb,
  input logic                      rdFlag,
  input logic [CNT_W-1:0]          bitCnt,
  input logic                      selSync
);

  localparam int FRAME = 1 + ADDR_W + DATA_W;

  assert_frame_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(FRAME));

  assert_cfg_change_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgOut) |-> $past(strb.commitWrite));

  assert_oe_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdOe) |-> $past(rdFlag) && $past(bitCnt) == CNT_W'(ADDR_W + 1));

  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    sdOe && $past(sdOe) && !$past(strb.shiftRead) |-> $stable(sdOut));

  assert_oe_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !selIn && $past(!selIn) && $past(!selIn, 2) && $past(!selIn, 3) |-> !sdOe);

  assert_abort_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(!selSync) |-> bitCnt == '0 && !sdOe);

endmodule

bind serial_reg_slave serial_reg_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CFG(NUM_CFG), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .selIn(selIn), .sdOut(sdOut), .sdOe(sdOe),
  .cfgOut(cfgOut), .strb(strb), .rdFlag(rdFlag), .bitCnt(bitCnt), .selSync(selSync)
);

// File: tb/sim_serial_reg_slave.sv
module sim_serial_reg_slave;

  localparam int NCFG = 4;
  localparam int NSTAT = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selIn = 1'b0;
  logic sclkIn = 1'b0;
  logic sdIn = 1'b0;
  logic sdOut;
  logic sdOe;
  logic [NSTAT*8-1:0] statusIn = '0;
  logic [NCFG*8-1:0] cfgOut;

  int nChecks = 0;
  int nFail = 0;
  int mdl[NCFG];
  bit idle = 1'b0;
  int idleBad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_reg_slave u0 (
    .clk(clk), .rstN(rstN), .selIn(selIn), .sclkIn(sclkIn), .sdIn(sdIn),
    .sdOut(sdOut), .sdOe(sdOe), .statusIn(statusIn), .cfgOut(cfgOut)
  );

  // Between frames the configuration bank must match the model on every clock.
  always @(negedge clk) begin
    if (idle) begin
      for (int i = 0; i < NCFG; i++)
        if (int'(cfgOut[i*8 +: 8]) != mdl[i]) idleBad++;
      if (sdOe !== 1'b0) idleBad++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic checkBank(input string req);
    for (int i = 0; i < NCFG; i++)
      check(int'(cfgOut[i*8 +: 8]) == mdl[i], req, int'(cfgOut[i*8 +: 8]), mdl[i]);
  endtask

  // Drives one frame of nBits bits (16 for a full frame); returns read data and
  // the number of bit times where sdOe differed from the expected window.
  task automatic xfer(input bit rd, input int addr, input int data, input int nBits,
                      output int got, output int oeBad);
    bit expOe;
    got = 0;
    oeBad = 0;
    idle = 1'b0;
    @(negedge clk);
    selIn = 1'b1;
    sclkIn = 1'b0;
    #100;
    for (int b = 0; b < nBits; b++) begin
      sclkIn = 1'b0;
      if (b == 0) sdIn = rd;
      else if (b < 8) sdIn = addr[b-1];
      else sdIn = rd ? 1'b0 : data[b-8];
      #40;
      expOe = rd && (b >= 8);
      if (sdOe !== expOe) oeBad++;
      if (expOe) got[b-8] = sdOut;
      #10 sclkIn = 1'b1;
      #50;
    end
    sclkIn = 1'b0;
    #50;
    selIn = 1'b0;
    #100;
    if (!rd && nBits == 16 && addr < NCFG) mdl[addr] = data;
    idle = 1'b1;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      summary();
    end
  end

  initial begin
    int got;
    int oeBad;
    for (int i = 0; i < NCFG; i++) mdl[i] = 8'h30 + i;
    repeat (4) @(negedge clk);
    // R1: defaults held during reset
    checkBank("R1 defaults in reset");
    check(sdOe == 1'b0, "R1 oe in reset", sdOe, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkBank("R1 defaults after reset");
    idle = 1'b1;

    // R2 R3: write to address 2 (LSB-first address, LSB-first data)
    xfer(1'b0, 2, 8'h5C, 16, got, oeBad);
    checkBank("R3 write 0x5C to reg 2");
    check(oeBad == 0, "R5 oe low during write", oeBad, 0);

    // R4 R5: read back
    xfer(1'b1, 2, 0, 16, got, oeBad);
    check(got == 8'h5C, "R4 read reg 2", got, 8'h5C);
    check(oeBad == 0, "R5 oe window on read", oeBad, 0);

    // R2: asymmetric data pattern on reg 1, read of untouched reg 0
    xfer(1'b0, 1, 8'h81, 16, got, oeBad);
    checkBank("R2 write 0x81 to reg 1");
    xfer(1'b1, 1, 0, 16, got, oeBad);
    check(got == 8'h81, "R2 read reg 1", got, 8'h81);
    xfer(1'b1, 0, 0, 16, got, oeBad);
    check(got == 8'h30, "R1 default reg 0 via read", got, 8'h30);
    xfer(1'b0, 3, 8'h0F, 16, got, oeBad);
    checkBank("R3 write reg 3");

    // R7: live status bytes
    statusIn = 16'h3CA5;
    xfer(1'b1, 16, 0, 16, got, oeBad);
    check(got == 8'hA5, "R7 status byte 0", got, 8'hA5);
    xfer(1'b1, 17, 0, 16, got, oeBad);
    check(got == 8'h3C, "R7 status byte 1", got, 8'h3C);
    statusIn = 16'h6E00;
    xfer(1'b0, 17, 8'hFF, 16, got, oeBad);
    checkBank("R7 write to status ignored");
    xfer(1'b1, 17, 0, 16, got, oeBad);
    check(got == 8'h6E, "R7 status byte 1 live", got, 8'h6E);

    // R8: unmapped addresses
    xfer(1'b1, 85, 0, 16, got, oeBad);
    check(got == 0, "R8 unmapped read zero", got, 0);
    check(oeBad == 0, "R5 oe window unmapped read", oeBad, 0);
    xfer(1'b0, 127, 8'hEE, 16, got, oeBad);
    checkBank("R8 unmapped write ignored");
    xfer(1'b0, 64, 8'hEE, 16, got, oeBad);
    checkBank("R8 write with high address bit ignored");

    // R6: abort a write after 12 bits, then a read in its data phase
    xfer(1'b0, 2, 8'hAA, 12, got, oeBad);
    checkBank("R6 aborted write leaves reg");
    xfer(1'b1, 2, 0, 11, got, oeBad);
    check(sdOe == 1'b0, "R6 oe low after abort", sdOe, 0);
    // R9: the next full frames decode from bit 0
    xfer(1'b1, 2, 0, 16, got, oeBad);
    check(got == 8'h5C, "R9 read after aborts", got, 8'h5C);
    xfer(1'b0, 0, 8'hC3, 16, got, oeBad);
    xfer(1'b1, 0, 0, 16, got, oeBad);
    check(got == 8'hC3, "R9 back-to-back write/read", got, 8'hC3);
    checkBank("R9 bank after sequence");

    check(idleBad == 0, "R3 per-clock idle compare", idleBad, 0);
    done = 1'b1;
    summary();
  end

endmodule